// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker

This block monitors a 10-bit standard-definition video word stream and finds ancillary data packets in it. Each packet opens with the three-word preamble 000h, 3FFh, 3FFh. That is followed by the type word, the secondary type word, a count word, the user words and a final checksum word. While the packet passes, the block adds up a running checksum. When the checksum word arrives, it compares that word with the value it expects. A mismatch produces a one-cycle error pulse and sets a status bit that stays set until the host clears it.

The host can limit which packets are checked by loading a small match table. Each entry holds a type code, a secondary type code and an enable bit. When every enable bit is clear, all packets are checked. This is the default. The block only watches the stream: it does not extract, store or alter any word.

Top module: `anc_csum_chk`

## Requirements
- R1: After reset, `err_pulse` and `err_sticky` are 0, and no packet is in progress.
- R2: A packet starts after three consecutive valid words 000h, 3FFh, 3FFh. The next valid word is the type word, then the secondary type word, then the count word.
- R3: Cycles with `din_vld` low are ignored, whatever value `din` carries. This holds both inside a preamble and inside a packet.
- R4: The expected checksum word has bits 8..0 equal to the 9-bit sum, modulo 512, of bits 8..0 of every word from the type word through the last user word. Its bit 9 is the inverse of its bit 8. A difference in any of the 10 bits is a mismatch.
- R5: The number of user words equals bits 7..0 of the count word. A count of 0 makes the next valid word the checksum word.
- R6: Filter entry i matches a packet when `flt_en[i]` is 1, bits 7..0 of the type word equal `flt_did[8i+7:8i]`, and bits 7..0 of the secondary type word equal `flt_sdid[8i+7:8i]`. When `flt_en` is all zero, every packet is checked. Otherwise only packets that match an entry can raise an error.
- R7: A checked mismatch drives `err_pulse` high for exactly one cycle. That cycle follows the clock edge that captures the checksum word.
- R8: `err_sticky` is set in the same cycle as `err_pulse`. It stays set until an edge where `sticky_clr` is 1, after which it reads 0.
- R9: If a new error and `sticky_clr` fall on the same edge, `err_sticky` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 10 | Video data word |
| din_vld | input | 1 | Marks `din` as a valid word |
| flt_en | input | 4 | Per-entry enables of the type filter |
| flt_did | input | 32 | Type codes, 8 bits per entry |
| flt_sdid | input | 32 | Secondary type codes, 8 bits per entry |
| sticky_clr | input | 1 | Write-one clear of `err_sticky` |
| err_pulse | output | 1 | One-cycle checksum error pulse |
| err_sticky | output | 1 | Sticky checksum error status |

## Verification
The checker has a single register stage between the checksum word and its results. Both `err_pulse` and `err_sticky` respond at the clock edge that captures the checksum word. The bench drives each word at a falling edge, so it reads both outputs at the next falling edge, and it reads `err_pulse` again one cycle later to confirm the pulse has dropped. A clear is checked at the falling edge after the edge that samples `sticky_clr`. The case where a clear and an error arrive together is tested by raising `sticky_clr` on the same word as a bad checksum.

// File: rtl/anc_chk_pkg.sv
`timescale 1ns/1ps
package anc_chk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DID,
      ST_SDID,
      ST_DC,
      ST_UDW,
      ST_CS
   } anc_st_t;
endpackage

// File: rtl/anc_preamble_det.sv
`timescale 1ns/1ps
module anc_preamble_det #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         din_vld,
   output logic         pre_hit
);
   localparam logic [W-1:0] CODE_LO = '0;
   localparam logic [W-1:0] CODE_HI = '1;

   logic seen_lo;     // last valid word was all zeros
   logic seen_lo_hi;  // last two valid words were zeros then ones

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_lo    <= 1'b0;
         seen_lo_hi <= 1'b0;
      end else if (din_vld) begin
         seen_lo    <= (din == CODE_LO);
         seen_lo_hi <= seen_lo && (din == CODE_HI);
      end
   end

   assign pre_hit = din_vld && seen_lo_hi && (din == CODE_HI);

   // R3: an invalid cycle leaves the preamble tracking untouched
   a_r3_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !din_vld |=> ($stable(seen_lo) && $stable(seen_lo_hi)));
endmodule

// File: rtl/anc_type_filter.sv
`timescale 1ns/1ps
module anc_type_filter #(
   parameter int N_ENT = 4,
   parameter int IDW   = 8
) (
   input  logic [N_ENT-1:0]     flt_en,
   input  logic [N_ENT*IDW-1:0] flt_did,
   input  logic [N_ENT*IDW-1:0] flt_sdid,
   input  logic [IDW-1:0]       pkt_did,
   input  logic [IDW-1:0]       pkt_sdid,
   output logic                 sel
);
   logic [N_ENT-1:0] hit;

   generate
      if (N_ENT < 1) begin : g_bad_cfg
         $error("anc_type_filter: N_ENT must be at least 1");
      end
      for (genvar i = 0; i < N_ENT; i++) begin : g_ent
         assign hit[i] = flt_en[i]
                      && (flt_did[i*IDW +: IDW]  == pkt_did)
                      && (flt_sdid[i*IDW +: IDW] == pkt_sdid);
      end
   endgenerate

   assign sel = (flt_en == '0) || (|hit);
endmodule

// File: rtl/anc_csum_fsm.sv
`timescale 1ns/1ps
module anc_csum_fsm
   import anc_chk_pkg::*;
#(
   parameter int W     = 10,
   parameter int IDW   = 8,
   parameter int CNT_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   din,
   input  logic           din_vld,
   input  logic           pre_hit,
   output logic           cs_cyc,
   output logic           cs_bad,
   output logic [IDW-1:0] pkt_did,
   output logic [IDW-1:0] pkt_sdid
);
   localparam int SW = W - 1;

   anc_st_t          st;
   logic [SW-1:0]    sum;
   logic [CNT_W-1:0] cnt;
   logic [SW-1:0]    add_v;
   logic [W-1:0]     exp_word;

   generate
      if (CNT_W > SW || IDW > SW) begin : g_bad_cfg
         $error("anc_csum_fsm: fields wider than checksum span");
      end
   endgenerate

   assign add_v = sum + din[SW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sum      <= '0;
         cnt      <= '0;
         pkt_did  <= '0;
         pkt_sdid <= '0;
      end else if (din_vld) begin
         unique case (st)
            ST_IDLE: if (pre_hit) st <= ST_DID;
            ST_DID: begin
               sum     <= din[SW-1:0];
               pkt_did <= din[IDW-1:0];
               st      <= ST_SDID;
            end
            ST_SDID: begin
               sum      <= add_v;
               pkt_sdid <= din[IDW-1:0];
               st       <= ST_DC;
            end
            ST_DC: begin
               sum <= add_v;
               cnt <= din[CNT_W-1:0];
               st  <= (din[CNT_W-1:0] == '0) ? ST_CS : ST_UDW;
            end
            ST_UDW: begin
               sum <= add_v;
               cnt <= cnt - 1'b1;
               if (cnt == CNT_W'(1)) st <= ST_CS;
            end
            ST_CS:   st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign exp_word = {~sum[SW-1], sum};
   assign cs_cyc   = din_vld && (st == ST_CS);
   assign cs_bad   = (din != exp_word);

   // R5: the user-word phase never runs with an exhausted count
   a_r5_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UDW) |-> (cnt != '0));
   // R2: a detected preamble in idle leads to the type word
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_hit && st == ST_IDLE) |=> (st == ST_DID));
endmodule

// File: rtl/anc_csum_chk.sv
`timescale 1ns/1ps
module anc_csum_chk #(
   parameter int W     = 10,
   parameter int N_ENT = 4,
   parameter int IDW   = 8,
   parameter int CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         din,
   input  logic                 din_vld,
   input  logic [N_ENT-1:0]     flt_en,
   input  logic [N_ENT*IDW-1:0] flt_did,
   input  logic [N_ENT*IDW-1:0] flt_sdid,
   input  logic                 sticky_clr,
   output logic                 err_pulse,
   output logic                 err_sticky
);
   logic           pre_hit;
   logic           cs_cyc;
   logic           cs_bad;
   logic           sel;
   logic [IDW-1:0] pkt_did;
   logic [IDW-1:0] pkt_sdid;
   logic           new_err;

   generate
      if (W < 3) begin : g_bad_w
         $error("anc_csum_chk: word width too small");
      end
   endgenerate

   anc_preamble_det #(.W(W)) u_pre (
      .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
      .pre_hit(pre_hit)
   );

   anc_csum_fsm #(.W(W), .IDW(IDW), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
      .pre_hit(pre_hit), .cs_cyc(cs_cyc), .cs_bad(cs_bad),
      .pkt_did(pkt_did), .pkt_sdid(pkt_sdid)
   );

   anc_type_filter #(.N_ENT(N_ENT), .IDW(IDW)) u_flt (
      .flt_en(flt_en), .flt_did(flt_did), .flt_sdid(flt_sdid),
      .pkt_did(pkt_did), .pkt_sdid(pkt_sdid), .sel(sel)
   );

   assign new_err = cs_cyc && cs_bad && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pulse  <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         err_pulse <= new_err;
         if (new_err)         err_sticky <= 1'b1;
         else if (sticky_clr) err_sticky <= 1'b0;
      end
   end

   // R7: the error pulse lasts one cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);
   // R8: a pulse is always reflected in the status bit
   a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> err_sticky);
   // R8: the status bit holds without a clear
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !sticky_clr) |=> err_sticky);
   // R9: after a clear the status equals whether a new error landed
   a_r9_clr_prio: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_clr |=> (err_sticky == err_pulse));
   // R6: a packet rejected by the filter never pulses
   a_r6_filtered: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_cyc && !sel) |=> !err_pulse);
endmodule

// File: tb/sim_anc_csum_chk.sv
`timescale 1ns/1ps
module sim_anc_csum_chk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  din = '0;
   logic        din_vld = 1'b0;
   logic [3:0]  flt_en = '0;
   logic [31:0] flt_did = '0;
   logic [31:0] flt_sdid = '0;
   logic        sticky_clr = 1'b0;
   logic        err_pulse;
   logic        err_sticky;

   int n_chk = 0;
   int n_bad = 0;
   bit exp_sticky = 1'b0;
   int gap_pct = 25;

   always #4 clk = ~clk;

   anc_csum_chk u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
      .flt_en(flt_en), .flt_did(flt_did), .flt_sdid(flt_sdid),
      .sticky_clr(sticky_clr), .err_pulse(err_pulse), .err_sticky(err_sticky)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic bit sel_f(input logic [7:0] d, input logic [7:0] s);
      if (flt_en == '0) return 1'b1;
      for (int i = 0; i < 4; i++)
         if (flt_en[i] && flt_did[i*8 +: 8] == d && flt_sdid[i*8 +: 8] == s)
            return 1'b1;
      return 1'b0;
   endfunction

   // R3: invalid cycles carrying preamble-like junk
   task automatic put(input logic [9:0] w, input bit clr);
      if (int'($urandom_range(99)) < gap_pct) begin
         @(negedge clk);
         din_vld    = 1'b0;
         din        = $urandom_range(1) ? 10'h3FF : 10'h000;
         sticky_clr = 1'b0;
      end
      @(negedge clk);
      din        = w;
      din_vld    = 1'b1;
      sticky_clr = clr;
   endtask

   task automatic send_pkt(input logic [7:0] d, input logic [7:0] s,
                           input int n, input int flip, input bit clr_cs);
      logic [8:0] sum;
      logic [9:0] w;
      logic [9:0] cs;
      bit exp_err;
      put(10'h000, 0); put(10'h3FF, 0); put(10'h3FF, 0);
      w = {2'b01, d};        put(w, 0); sum = w[8:0];
      w = {2'b10, s};        put(w, 0); sum = sum + w[8:0];
      w = {2'b10, 8'(n)};    put(w, 0); sum = sum + w[8:0];
      for (int k = 0; k < n; k++) begin
         w = 10'($urandom_range(10'h3FB, 10'h004));
         put(w, 0);
         sum = sum + w[8:0];
      end
      cs = {~sum[8], sum};
      if (flip >= 0) cs[flip] = ~cs[flip];
      put(cs, clr_cs);
      @(negedge clk);
      din_vld    = 1'b0;
      sticky_clr = 1'b0;
      exp_err    = (flip >= 0) && sel_f(d, s);
      exp_sticky = exp_err || (exp_sticky && !clr_cs);
      check("R4/R6/R7 pulse after checksum", err_pulse, exp_err);
      check(clr_cs ? "R9 sticky with clear" : "R8 sticky", err_sticky, exp_sticky);
      @(negedge clk);
      check("R7 pulse drops", err_pulse, 1'b0);
   endtask

   task automatic clear_sticky();
      @(negedge clk); sticky_clr = 1'b1;
      @(negedge clk); sticky_clr = 1'b0;
      exp_sticky = 1'b0;
      check("R8 clear", err_sticky, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd7151));
      #1;
      check("R1 reset pulse", err_pulse, 1'b0);
      check("R1 reset sticky", err_sticky, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 pulse after reset", err_pulse, 1'b0);

      // R2/R4: clean packet, then bit-0 and bit-9 corruptions
      send_pkt(8'h41, 8'h05, 4, -1, 0);
      send_pkt(8'h41, 8'h05, 4, 0, 0);
      send_pkt(8'h60, 8'h60, 3, 9, 0);
      clear_sticky();
      // R5: zero user words
      send_pkt(8'h50, 8'h01, 0, -1, 0);
      send_pkt(8'h50, 8'h01, 0, 5, 0);
      clear_sticky();
      // R5: long packet
      send_pkt(8'h61, 8'h02, 200, 3, 0);
      // R9: clear on the same edge as a new error
      send_pkt(8'h62, 8'h03, 2, 8, 1);
      check("R9 stays set", err_sticky, 1'b1);
      clear_sticky();
      // R3: heavy gaps
      gap_pct = 80;
      send_pkt(8'h10, 8'h20, 6, -1, 0);
      send_pkt(8'h10, 8'h20, 6, 2, 0);
      gap_pct = 25;
      clear_sticky();
      // R6: filter rejects a bad packet, then matches one
      flt_en = 4'b0100; flt_did[16 +: 8] = 8'hA0; flt_sdid[16 +: 8] = 8'h0B;
      send_pkt(8'hA0, 8'h0C, 3, 1, 0);
      check("R6 rejected leaves sticky clear", err_sticky, 1'b0);
      send_pkt(8'hA0, 8'h0B, 3, 1, 0);
      clear_sticky();

      // random mix
      for (int r = 0; r < 60; r++) begin
         logic [7:0] d;
         logic [7:0] s;
         flt_en   = ($urandom_range(2) == 0) ? 4'b0000 : 4'($urandom_range(15));
         flt_did  = $urandom;
         flt_sdid = $urandom;
         if ($urandom_range(1)) begin
            int e = $urandom_range(3);
            d = flt_did[e*8 +: 8];
            s = flt_sdid[e*8 +: 8];
         end else begin
            d = 8'($urandom);
            s = 8'($urandom);
         end
         send_pkt(d, s, $urandom_range(12),
                  ($urandom_range(1) != 0) ? int'($urandom_range(9)) : -1,
                  $urandom_range(3) == 0);
         if ($urandom_range(4) == 0) clear_sticky();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule